// File: doc/BRIEF.md
# Memory Protection Entry Configuration Register File

This block stores the configuration of a set of physical memory protection entries and guards every software write to it. Each entry has an 8-bit configuration byte and an address word. A machine security register with three control bits sits beside them. Software reaches all of this through one indexed access port that selects one of three register kinds: packed configuration words, per-entry address words, or the security register.

The block decides whether each write is accepted. The decision depends on the lock bit of the entry being written, on the lock and mode of the next entry up, on the security bits, and in some cases on the value being written. Accepted writes land on the next clock edge. The full configuration and address arrays are driven out as flat vectors to the range decode and permission check logic downstream. A one-cycle change pulse tells that logic when to refresh. The security extension is a parameter; without it, the security register reads as zero and only the lock bits govern writes.

Top module: `pmp_csr_regfile`

## Requirements
- R1: While reset is low, and after it is released, every configuration byte, every address word and all three security bits are zero, and the change pulse is low.
- R2: `csr_kind` 0 selects configuration words. Word `k` holds the bytes of entries `4k` to `4k+3` (DW=32), with entry `4k+b` at bits `[8b+7:8b]`. Bytes whose entry index is at or above NUM_ENTRIES read as zero, and writes to them change nothing.
- R3: Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits [4:3] match mode (01 = top-of-range), bit 7 lock. With the bypass bit and the lockdown bit both clear, a byte write to a locked entry is dropped and a byte write to an unlocked entry is stored.
- R4: When the bypass bit is set, byte writes are stored whatever the lock state of the entry.
- R5: When the lockdown bit is set and the bypass bit is clear, acceptance depends only on the written byte. It is accepted if it has lock=1 and execute=0, or if it has lock=0 and bits [2:0] not equal to 110. Otherwise it is dropped, even for an unlocked entry.
- R6: `csr_kind` 1 selects address word `idx`. A write is dropped if entry `idx` is locked, or if entry `idx+1` exists, is locked and has mode 01. Indices at or above NUM_ENTRIES read zero and are never written.
- R7: `csr_kind` 2 selects the security register: bit 0 lockdown, bit 1 deny-by-default, bit 2 bypass, other bits read zero. Once set, lockdown and deny-by-default cannot be cleared by a write.
- R8: A write cannot set the bypass bit while it is clear and any entry is locked. The bypass bit can be cleared at any time.
- R9: `rule_changed_o` is high for exactly the one cycle after a write that stores at least one configuration byte or an address word. It stays low after dropped writes and after security register writes.
- R10: With `csr_we` low, or with `csr_kind` 3, no stored state changes.
- R11: With SEC_EXT=0 the security register reads zero and ignores writes, so a locked entry cannot be rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe |
| csr_kind | input | 2 | Register kind: 0 config word, 1 address, 2 security, 3 none |
| csr_idx | input | IDX_W | Register index within the kind |
| csr_wdata | input | DW | Write data |
| csr_rdata | output | DW | Combinational read data for kind and index |
| cfg_o | output | NUM_ENTRIES*8 | All configuration bytes, entry i at [8i+7:8i] |
| addr_o | output | NUM_ENTRIES*AW | All address words, entry i at [AW*i+AW-1:AW*i] |
| sec_lockdown_o | output | 1 | Lockdown bit |
| sec_denydef_o | output | 1 | Deny-by-default bit |
| sec_bypass_o | output | 1 | Lock bypass bit |
| rule_changed_o | output | 1 | One-cycle pulse after an accepted entry write |

## Verification
The hardest state to reach is lockdown set with entries locked, followed by value-dependent writes to those locked entries. Reaching it takes a fixed order of steps. Bypass must be raised before anything is locked, because the rule in R8 blocks it afterwards. Then entries are locked, lockdown is raised, and bypass is dropped. Directed sequences build this state, and the bench then tries each byte pattern of R5 against both locked and unlocked entries. Seeded random rounds, each started from reset, then mix in writes to every register kind, including out-of-range indices and locked top-of-range neighbours, and compare everything against a bench model.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

   typedef enum logic [1:0] {
      KIND_CFG  = 2'd0,
      KIND_ADDR = 2'd1,
      KIND_SEC  = 2'd2,
      KIND_NONE = 2'd3
   } csr_kind_e;

   localparam int BIT_PERM_R = 0;
   localparam int BIT_PERM_W = 1;
   localparam int BIT_PERM_X = 2;
   localparam int BIT_MODE_LO = 3;
   localparam int BIT_LOCK = 7;

   localparam logic [1:0] MODE_TOP_OF_RANGE = 2'b01;
   localparam logic [2:0] PERM_WX_ONLY = 3'b110;

   localparam int SEC_LOCKDOWN = 0;
   localparam int SEC_DENYDEF  = 1;
   localparam int SEC_BYPASS   = 2;

endpackage

// File: rtl/pmp_cfg_accept.sv
module pmp_cfg_accept
   import pmp_csr_pkg::*;
#(
   parameter bit SEC_EXT = 1'b1
) (
   input  logic [7:0] cur_cfg,
   input  logic [7:0] new_cfg,
   input  logic       bypass,
   input  logic       lockdown,
   output logic       accept
);

   logic cur_locked;
   assign cur_locked = cur_cfg[BIT_LOCK];

   logic unused_cur;
   assign unused_cur = ^{cur_cfg[6:0], new_cfg[6:3]};

   generate
      if (SEC_EXT) begin : g_ext
         logic lock_no_exec;
         logic open_not_wx;
         assign lock_no_exec = new_cfg[BIT_LOCK] & ~new_cfg[BIT_PERM_X];
         assign open_not_wx  = ~new_cfg[BIT_LOCK] &
                               (new_cfg[BIT_PERM_X:BIT_PERM_R] != PERM_WX_ONLY);
         always_comb begin
            if (bypass) begin
               accept = 1'b1;
            end else if (lockdown) begin
               accept = lock_no_exec | open_not_wx;
            end else begin
               accept = ~cur_locked;
            end
         end
      end else begin : g_plain
         logic unused_sec;
         assign unused_sec = ^{bypass, lockdown, new_cfg[BIT_LOCK], new_cfg[2:0]};
         assign accept = ~cur_locked;
      end
   endgenerate

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
   import pmp_csr_pkg::*;
#(
   parameter bit SEC_EXT = 1'b1,
   parameter int DW      = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          any_locked,
   output logic          lockdown,
   output logic          denydef,
   output logic          bypass
);

   logic unused_hi;
   assign unused_hi = ^wdata[DW-1:3];

   generate
      if (SEC_EXT) begin : g_ext
         logic ld_q, dd_q, bp_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ld_q <= 1'b0;
               dd_q <= 1'b0;
               bp_q <= 1'b0;
            end else if (wr_en) begin
               ld_q <= ld_q | wdata[SEC_LOCKDOWN];
               dd_q <= dd_q | wdata[SEC_DENYDEF];
               bp_q <= wdata[SEC_BYPASS] & (bp_q | ~any_locked);
            end
         end
         assign lockdown = ld_q;
         assign denydef  = dd_q;
         assign bypass   = bp_q;
      end else begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, wr_en, wdata[2:0], any_locked};
         assign lockdown = 1'b0;
         assign denydef  = 1'b0;
         assign bypass   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pmp_csr_rdmux.sv
module pmp_csr_rdmux
   import pmp_csr_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int DW          = 32,
   parameter int AW          = 32,
   parameter int IDX_W       = 8
) (
   input  logic [1:0]                rd_kind,
   input  logic [IDX_W-1:0]          rd_idx,
   input  logic [NUM_ENTRIES*8-1:0]  cfg_flat,
   input  logic [NUM_ENTRIES*AW-1:0] addr_flat,
   input  logic [2:0]                sec_bits,
   output logic [DW-1:0]             rdata
);

   localparam int BPC = DW / 8;

   always_comb begin
      rdata = '0;
      case (csr_kind_e'(rd_kind))
         KIND_CFG: begin
            for (int b = 0; b < BPC; b++) begin
               if (int'(rd_idx) * BPC + b < NUM_ENTRIES) begin
                  rdata[b*8 +: 8] = cfg_flat[(int'(rd_idx) * BPC + b) * 8 +: 8];
               end
            end
         end
         KIND_ADDR: begin
            if (int'(rd_idx) < NUM_ENTRIES) begin
               rdata[AW-1:0] = addr_flat[int'(rd_idx) * AW +: AW];
            end
         end
         KIND_SEC: begin
            rdata[2:0] = sec_bits;
         end
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/pmp_csr_regfile.sv
module pmp_csr_regfile
   import pmp_csr_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int DW          = 32,
   parameter int AW          = 32,
   parameter int IDX_W       = 8,
   parameter bit SEC_EXT     = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      csr_we,
   input  logic [1:0]                csr_kind,
   input  logic [IDX_W-1:0]          csr_idx,
   input  logic [DW-1:0]             csr_wdata,
   output logic [DW-1:0]             csr_rdata,
   output logic [NUM_ENTRIES*8-1:0]  cfg_o,
   output logic [NUM_ENTRIES*AW-1:0] addr_o,
   output logic                      sec_lockdown_o,
   output logic                      sec_denydef_o,
   output logic                      sec_bypass_o,
   output logic                      rule_changed_o
);

   localparam int BPC = DW / 8;

   generate
      if (DW != 32 && DW != 64) begin : g_bad_dw
         $error("pmp_csr_regfile: DW must be 32 or 64");
      end
      if (AW < 1 || AW > DW) begin : g_bad_aw
         $error("pmp_csr_regfile: AW must be in 1..DW");
      end
      if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_n
         $error("pmp_csr_regfile: NUM_ENTRIES must be in 1..64");
      end
      if ((1 << IDX_W) < NUM_ENTRIES) begin : g_bad_idx
         $error("pmp_csr_regfile: IDX_W too narrow for NUM_ENTRIES");
      end
   endgenerate

   csr_kind_e kind;
   assign kind = csr_kind_e'(csr_kind);

   logic [NUM_ENTRIES*8-1:0]  cfg_q;
   logic [NUM_ENTRIES*AW-1:0] addr_q;
   logic [NUM_ENTRIES*8-1:0]  cfg_new;
   logic [NUM_ENTRIES-1:0]    cfg_wr, addr_wr, lock_v, tor_v;
   logic                      rc_q;
   logic                      lockdown, denydef, bypass, any_locked;

   assign any_locked = |lock_v;

   generate
      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
         localparam int CSR_NO  = i / BPC;
         localparam int BYTE_NO = i % BPC;
         logic cfg_hit, addr_hit, cfg_ok, nxt_guard;

         assign cfg_new[i*8 +: 8] = csr_wdata[BYTE_NO*8 +: 8];
         assign lock_v[i] = cfg_q[i*8 + BIT_LOCK];
         assign tor_v[i]  = (cfg_q[i*8 + BIT_MODE_LO +: 2] == MODE_TOP_OF_RANGE);

         assign cfg_hit  = csr_we && (kind == KIND_CFG) &&
                           (csr_idx == IDX_W'(CSR_NO));
         assign addr_hit = csr_we && (kind == KIND_ADDR) &&
                           (csr_idx == IDX_W'(i));

         pmp_cfg_accept #(.SEC_EXT(SEC_EXT)) u_accept (
            .cur_cfg  (cfg_q[i*8 +: 8]),
            .new_cfg  (cfg_new[i*8 +: 8]),
            .bypass   (bypass),
            .lockdown (lockdown),
            .accept   (cfg_ok)
         );

         if (i + 1 < NUM_ENTRIES) begin : g_nxt
            assign nxt_guard = lock_v[i+1] & tor_v[i+1];
         end else begin : g_top
            assign nxt_guard = 1'b0;
         end

         assign cfg_wr[i]  = cfg_hit & cfg_ok;
         assign addr_wr[i] = addr_hit & ~lock_v[i] & ~nxt_guard;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         addr_q <= '0;
         rc_q   <= 1'b0;
      end else begin
         for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (cfg_wr[i]) begin
               cfg_q[i*8 +: 8] <= cfg_new[i*8 +: 8];
            end
            if (addr_wr[i]) begin
               addr_q[i*AW +: AW] <= csr_wdata[AW-1:0];
            end
         end
         rc_q <= (|cfg_wr) | (|addr_wr);
      end
   end

   pmp_sec_reg #(.SEC_EXT(SEC_EXT), .DW(DW)) u_sec (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (csr_we && (kind == KIND_SEC)),
      .wdata      (csr_wdata),
      .any_locked (any_locked),
      .lockdown   (lockdown),
      .denydef    (denydef),
      .bypass     (bypass)
   );

   pmp_csr_rdmux #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .DW          (DW),
      .AW          (AW),
      .IDX_W       (IDX_W)
   ) u_rdmux (
      .rd_kind   (csr_kind),
      .rd_idx    (csr_idx),
      .cfg_flat  (cfg_q),
      .addr_flat (addr_q),
      .sec_bits  ({bypass, denydef, lockdown}),
      .rdata     (csr_rdata)
   );

   assign cfg_o          = cfg_q;
   assign addr_o         = addr_q;
   assign sec_lockdown_o = lockdown;
   assign sec_denydef_o  = denydef;
   assign sec_bypass_o   = bypass;
   assign rule_changed_o = rc_q;

endmodule

// File: rtl/pmp_csr_regfile_chk.sv
module pmp_csr_regfile_chk #(
   parameter int NUM_ENTRIES = 16,
   parameter int AW          = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      csr_we,
   input logic [1:0]                csr_kind,
   input logic [NUM_ENTRIES*8-1:0]  cfg_o,
   input logic [NUM_ENTRIES*AW-1:0] addr_o,
   input logic                      sec_lockdown_o,
   input logic                      sec_denydef_o,
   input logic                      sec_bypass_o,
   input logic                      rule_changed_o
);

   logic any_lock;
   always_comb begin
      any_lock = 1'b0;
      for (int i = 0; i < NUM_ENTRIES; i++) any_lock |= cfg_o[i*8+7];
   end

   assert_chg_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rule_changed_o |-> $past(csr_we && (csr_kind == 2'd0 || csr_kind == 2'd1)));

   assert_sticky_lockdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sec_lockdown_o |=> sec_lockdown_o);

   assert_sticky_denydef_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sec_denydef_o |=> sec_denydef_o);

   assert_bypass_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sec_bypass_o) |-> $past(!any_lock));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we || csr_kind == 2'd3) |=> ($stable(cfg_o) && $stable(addr_o)));

   generate
      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_e
         assert_addr_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_o[i*8+7] |=> $stable(addr_o[i*AW +: AW]));

         assert_cfg_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_o[i*8+7] && !sec_bypass_o && !sec_lockdown_o)
            |=> $stable(cfg_o[i*8 +: 8]));
      end
   endgenerate

endmodule

bind pmp_csr_regfile pmp_csr_regfile_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .AW          (AW)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .csr_we         (csr_we),
   .csr_kind       (csr_kind),
   .cfg_o          (cfg_o),
   .addr_o         (addr_o),
   .sec_lockdown_o (sec_lockdown_o),
   .sec_denydef_o  (sec_denydef_o),
   .sec_bypass_o   (sec_bypass_o),
   .rule_changed_o (rule_changed_o)
);

// File: tb/tb_pmp_csr_regfile.sv
`timescale 1ns/1ps
module tb_pmp_csr_regfile;

   localparam int N = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csr_we = 1'b0;
   logic [1:0] csr_kind = 2'd3;
   logic [7:0] csr_idx = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] rdata, p_rdata;
   logic [N*8-1:0] cfg_o, p_cfg;
   logic [N*32-1:0] addr_o, p_addr;
   logic ld, dd, bp, rc, p_ld, p_dd, p_bp, p_rc;

   always #10 clk = ~clk;

   pmp_csr_regfile #(.NUM_ENTRIES(N)) dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_kind(csr_kind),
      .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(rdata),
      .cfg_o(cfg_o), .addr_o(addr_o), .sec_lockdown_o(ld),
      .sec_denydef_o(dd), .sec_bypass_o(bp), .rule_changed_o(rc));

   pmp_csr_regfile #(.NUM_ENTRIES(N), .SEC_EXT(1'b0)) dut_plain (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_kind(csr_kind),
      .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(p_rdata),
      .cfg_o(p_cfg), .addr_o(p_addr), .sec_lockdown_o(p_ld),
      .sec_denydef_o(p_dd), .sec_bypass_o(p_bp), .rule_changed_o(p_rc));

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [7:0]  m_cfg [N];
   logic [31:0] m_addr [N];
   bit m_ld, m_dd, m_bp;

   task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit cfg_ok(input logic [7:0] cur, input logic [7:0] v);
      if (m_bp) return 1'b1;
      if (!m_ld) return !cur[7];
      return (v[7] && !v[2]) || (!v[7] && v[2:0] != 3'b110);
   endfunction

   function automatic logic [31:0] m_read(input logic [1:0] k, input int idx);
      logic [31:0] r = '0;
      if (k == 2'd0) begin
         for (int b = 0; b < 4; b++) if (idx*4 + b < N) r[b*8 +: 8] = m_cfg[idx*4 + b];
      end else if (k == 2'd1) begin
         if (idx < N) r = m_addr[idx];
      end else if (k == 2'd2) begin
         r = {29'b0, m_bp, m_dd, m_ld};
      end
      return r;
   endfunction

   task automatic chk_state(input string tag);
      logic [N*8-1:0] ec;
      logic [N*32-1:0] ea;
      for (int i = 0; i < N; i++) begin
         ec[i*8 +: 8] = m_cfg[i];
         ea[i*32 +: 32] = m_addr[i];
      end
      chk({tag, " cfg"}, 512'(cfg_o), 512'(ec));
      chk({tag, " addr"}, 512'(addr_o), 512'(ea));
      chk({tag, " sec"}, 512'({bp, dd, ld}), 512'({m_bp, m_dd, m_ld}));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      csr_we = 1'b0;
      csr_kind = 2'd3;
      repeat (3) @(negedge clk);
      for (int i = 0; i < N; i++) begin
         m_cfg[i] = '0;
         m_addr[i] = '0;
      end
      m_ld = 0; m_dd = 0; m_bp = 0;
      rst_n = 1'b1;
   endtask

   task automatic op(input logic [1:0] k, input int idx, input logic [31:0] d,
                     input string tag, input bit we = 1'b1);
      bit exp_chg = 0;
      bit anyl = 0;
      @(negedge clk);
      chk("R9 pulse width", 512'(rc), 512'(0));
      csr_we = we;
      csr_kind = k;
      csr_idx = 8'(idx);
      csr_wdata = d;
      if (we) begin
         if (k == 2'd0) begin
            for (int b = 0; b < 4; b++) begin
               if (idx*4 + b < N && cfg_ok(m_cfg[idx*4 + b], d[b*8 +: 8])) begin
                  m_cfg[idx*4 + b] = d[b*8 +: 8];
                  exp_chg = 1;
               end
            end
         end else if (k == 2'd1) begin
            if (idx < N) begin
               bit guard = (idx + 1 < N) && m_cfg[idx+1][7] && (m_cfg[idx+1][4:3] == 2'b01);
               if (!m_cfg[idx][7] && !guard) begin
                  m_addr[idx] = d;
                  exp_chg = 1;
               end
            end
         end else if (k == 2'd2) begin
            for (int i = 0; i < N; i++) anyl |= m_cfg[i][7];
            m_bp = d[2] && (m_bp || !anyl);
            m_ld = m_ld | d[0];
            m_dd = m_dd | d[1];
         end
      end
      @(negedge clk);
      csr_we = 1'b0;
      csr_kind = 2'd3;
      chk({tag, " R9 change pulse"}, 512'(rc), 512'(exp_chg));
      chk_state(tag);
   endtask

   task automatic rd(input logic [1:0] k, input int idx, input string tag);
      @(negedge clk);
      csr_we = 1'b0;
      csr_kind = k;
      csr_idx = 8'(idx);
      #1;
      chk({tag, " read"}, 512'(rdata), 512'(m_read(k, idx)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin
         m_cfg[i] = '0;
         m_addr[i] = '0;
      end
      m_ld = 0; m_dd = 0; m_bp = 0;
      @(negedge clk);
      chk("R1 cfg in reset", 512'(cfg_o), 512'(0));
      do_reset();
      chk_state("R1 after reset");
      chk("R1 pulse", 512'(rc), 512'(0));

      // R2 packing and out-of-range
      op(2'd0, 0, 32'h1A0B0C03, "R2 pack");
      rd(2'd0, 0, "R2 pack");
      op(2'd0, 4, 32'h01010101, "R2 out of range");
      rd(2'd0, 4, "R2 out of range");
      // R10 strobe low and kind 3
      op(2'd0, 1, 32'h05050505, "R10 no strobe", 1'b0);
      op(2'd3, 0, 32'hFFFFFFFF, "R10 kind none");
      // R6 address rules: entry 1 locked top-of-range
      op(2'd0, 0, 32'h00008B00, "R3 lock entry1");
      op(2'd1, 0, 32'h11111111, "R6 next tor locked");
      op(2'd1, 1, 32'h22222222, "R6 self locked");
      op(2'd1, 2, 32'h33333333, "R6 free");
      op(2'd1, 16, 32'h44444444, "R6 out of range");
      rd(2'd1, 16, "R6 out of range");
      rd(2'd1, 2, "R6 readback");
      // R3 locked word rejected entirely
      op(2'd0, 1, 32'h80808080, "R3 lock word");
      op(2'd0, 1, 32'h01010101, "R3 locked drop");
      // R8 bypass blocked while locked
      op(2'd2, 0, 32'h4, "R8 blocked");
      rd(2'd2, 0, "R8 blocked");

      // R4, R5, R7 sequence
      do_reset();
      op(2'd2, 0, 32'h4, "R8 set with none locked");
      op(2'd0, 0, 32'h00000080, "R4 lock e0");
      op(2'd0, 0, 32'h00000001, "R4 bypass write");
      op(2'd2, 0, 32'h5, "R7 lockdown on");
      op(2'd2, 0, 32'h1, "R8 clear bypass");
      op(2'd0, 0, 32'h00800001, "R5 lock no exec");
      op(2'd0, 0, 32'h00840001, "R5 lock with exec");
      op(2'd0, 0, 32'h00060001, "R5 wx only");
      op(2'd0, 0, 32'h00070001, "R5 rwx on locked");
      op(2'd0, 0, 32'h00070006, "R5 wx on unlocked");
      op(2'd2, 0, 32'h0, "R7 sticky");
      op(2'd2, 0, 32'h2, "R7 denydef");
      op(2'd2, 0, 32'h0, "R7 denydef sticky");
      rd(2'd2, 0, "R7 layout");

      // random rounds
      for (int r = 0; r < 6; r++) begin
         do_reset();
         for (int n = 0; n < 300; n++) begin
            int sel = $urandom % 20;
            logic [31:0] d = $urandom;
            for (int b = 0; b < 4; b++) if ($urandom % 4 != 0) d[b*8+7] = 1'b0;
            if (sel < 9) op(2'd0, $urandom % 5, d, "R3 R5 random cfg");
            else if (sel < 17) op(2'd1, $urandom % (N + 2), d, "R6 random addr");
            else if (sel < 18) op(2'd2, 0, $urandom % 8, "R8 random sec");
            else op(2'd3, $urandom % 4, d, "R10 random none");
            rd(2'($urandom % 4), $urandom % (N + 1), "R2 random");
         end
      end

      // R11 variant without the security extension
      do_reset();
      op(2'd2, 0, 32'h4, "R11 bypass main");
      @(negedge clk);
      csr_kind = 2'd2;
      #1;
      chk("R11 plain sec read", 512'(p_rdata), 512'(0));
      op(2'd0, 0, 32'h00000080, "R11 lock");
      op(2'd0, 0, 32'h00000003, "R11 rewrite");
      chk("R11 plain locked byte", 512'(p_cfg[7:0]), 512'(8'h80));
      chk("R11 plain bypass", 512'(p_bp), 512'(0));

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule